// File: doc/BRIEF.md
# Input Period Capture Channel

This block is one timer channel that measures the period of an external digital signal. A shared free-running counter bus is sampled each time the input shows an edge of the chosen polarity. Only edges of one direction count, so two successive samples bracket exactly one full period of the input.

The samples move through a three-deep pipeline. The newest value goes into a readable A register and into a hidden stage. On each new capture the older hidden value moves into the B stage. After the second capture, A holds the end of the period and B holds its start, so software takes A minus B. A sticky flag reports that a complete period is available, and software clears it. The synchronized pin level can be read at any time.

Top module: `period_capture_chan`

## Requirements
- R1: The channel captures only while `mode_i` equals 4'b0010. In any other mode, edges leave `reg_a_o`, `reg_b_o` and `flag_o` unchanged.
- R2: With `fall_sel_i`=0 only rising edges of the input capture. With `fall_sel_i`=1 only falling edges capture. Edges of the other direction have no effect on the registers.
- R3: A qualifying input edge makes `reg_a_o` take the value of `tbase_i`. The input passes two synchronizer flops and one edge-detect stage, so the load happens on the third rising clock edge after the input changes.
- R4: In the same capture event the hidden stage moves into B and takes the new sample. `reg_b_o` therefore shows the capture before the newest one, and it reads 0 after reset until two captures have occurred.
- R5: The first capture after entering the period mode does not set `flag_o`.
- R6: The second capture and every later one set `flag_o`.
- R7: `pin_level_o` follows the input two clock cycles late, in every mode and whether or not captures occur.
- R8: `flag_o` stays set until `flag_clr_i` is high for one clock. That clock then clears it.
- R9: If a flag clear and a flag-setting capture fall in the same cycle, the flag stays set.
- R10: Leaving the period mode or changing `fall_sel_i` restarts the sequence. The next capture counts as a first capture again and does not set the flag.
- R11: After a flagged capture, `reg_a_o` minus `reg_b_o` modulo 2^16 equals the input period, including when the counter wrapped once between the two edges.
- R12: Reset clears A, B, the hidden stage and the flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbase_i | input | 16 | Shared free-running counter bus |
| pin_i | input | 1 | Asynchronous input being measured |
| mode_i | input | 4 | Channel mode; 4'b0010 selects period capture |
| fall_sel_i | input | 1 | 0: capture on rising edges, 1: on falling edges |
| flag_clr_i | input | 1 | Software clear of the period flag |
| pin_level_o | output | 1 | Synchronized level of the input |
| reg_a_o | output | 16 | Newest capture |
| reg_b_o | output | 16 | Capture before the newest (older pipeline stage) |
| flag_o | output | 1 | Complete period captured |

## Verification
The bench checks that B reads the older stage and not the newest sample. A design that wired B to the hidden stage would show equal A and B after each capture. Edges of the wrong direction and edges outside the mode are driven to show that a design capturing on both edges, or regardless of mode, moves A. A change of polarity and a re-entry into the mode are each followed by one capture, which catches a design that keeps its first-capture memory and raises the flag too early. A clear is pulsed in the very cycle a capture sets the flag, and a counter wrap between two edges confirms that the modulo difference still gives the true period.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    localparam int MODE_W      = 4;
    localparam logic [MODE_W-1:0] PERIOD_MODE = 4'b0010;
endpackage

// File: rtl/pcap_edge_sync.sv
module pcap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic level_o,
    output logic strobe_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;
    logic  rise, fall;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin_i};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o  = st_q.chain[STAGES-1];
    assign rise     = st_q.chain[STAGES-1] & ~st_q.prev;
    assign fall     = ~st_q.chain[STAGES-1] & st_q.prev;
    assign strobe_o = fall_sel_i ? fall : rise;

    // R2: one qualifying edge gives a strobe one clock wide
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
endmodule

// File: rtl/pcap_capture_pipe.sv
module pcap_capture_pipe #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             pol_i,
    input  logic             strobe_i,
    input  logic [CNT_W-1:0] tbase_i,
    output logic [CNT_W-1:0] reg_a_o,
    output logic [CNT_W-1:0] reg_b_o,
    output logic             take_o,
    output logic             set_flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] a;
        logic [CNT_W-1:0] b1;
        logic [CNT_W-1:0] b2;
        logic             seen;
        logic             pol;
    } pipe_t;

    pipe_t st_d, st_q;
    logic  take, armed;

    assign take  = en_i & strobe_i;
    assign armed = en_i & st_q.seen & (pol_i == st_q.pol);

    always_comb begin
        st_d     = st_q;
        st_d.pol = pol_i;
        if (!en_i || (pol_i != st_q.pol)) st_d.seen = 1'b0;
        if (take) begin
            st_d.a    = tbase_i;
            st_d.b2   = st_q.b1;
            st_d.b1   = tbase_i;
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_a_o    = st_q.a;
    assign reg_b_o    = st_q.b2;
    assign take_o     = take;
    assign set_flag_o = take & armed;

    // R3: capture loads the counter bus into A
    a_r3_load_a: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> st_q.a == $past(tbase_i));
    // R4: the older hidden stage moves into B
    a_r4_shift_b: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> st_q.b2 == $past(st_q.b1));
    // R1: outside the mode the registers hold
    a_r1_hold_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(st_q.a) && $stable(st_q.b2)));
endmodule

// File: rtl/pcap_flag_ctrl.sv
module pcap_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R8: flag is sticky without a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    // R9: a set wins over a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> flag_o);
endmodule

// File: rtl/period_capture_chan.sv
module period_capture_chan #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          tbase_i,
    input  logic                      pin_i,
    input  logic [pcap_pkg::MODE_W-1:0] mode_i,
    input  logic                      fall_sel_i,
    input  logic                      flag_clr_i,
    output logic                      pin_level_o,
    output logic [CNT_W-1:0]          reg_a_o,
    output logic [CNT_W-1:0]          reg_b_o,
    output logic                      flag_o
);
    import pcap_pkg::*;

    logic active, strobe, take, set_flag;

    assign active = (mode_i == PERIOD_MODE);

    pcap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .fall_sel_i (fall_sel_i),
        .level_o    (pin_level_o),
        .strobe_o   (strobe)
    );

    pcap_capture_pipe #(.CNT_W(CNT_W)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (active),
        .pol_i      (fall_sel_i),
        .strobe_i   (strobe),
        .tbase_i    (tbase_i),
        .reg_a_o    (reg_a_o),
        .reg_b_o    (reg_b_o),
        .take_o     (take),
        .set_flag_o (set_flag)
    );

    pcap_flag_ctrl u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_flag),
        .clr_i  (flag_clr_i),
        .flag_o (flag_o)
    );

    // R1: no capture outside the period mode
    a_r1_no_take_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !take);
    // R5: a capture that is not armed leaves a clear flag clear
    a_r5_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !set_flag && !flag_o) |=> !flag_o);
    // R6: an armed capture raises the flag
    a_r6_flag_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag |=> flag_o);
endmodule

// File: tb/tb_period_capture_chan.sv
module tb_period_capture_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tbase = 16'h0;
    logic        pin = 1'b0;
    logic [3:0]  mode = 4'b0000;
    logic        fall_sel = 1'b0;
    logic        clr = 1'b0;
    logic        lvl;
    logic [15:0] ra, rb;
    logic        flag;
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    period_capture_chan dut (
        .clk(clk), .rst_n(rst_n), .tbase_i(tbase), .pin_i(pin),
        .mode_i(mode), .fall_sel_i(fall_sel), .flag_clr_i(clr),
        .pin_level_o(lvl), .reg_a_o(ra), .reg_b_o(rb), .flag_o(flag)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_pin(input logic v, input logic [15:0] tb);
        @(negedge clk);
        tbase = tb;
        pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 A", ra, 16'h0);
        chk("R12 B", rb, 16'h0);
        chk("R12 flag", {15'h0, flag}, 16'h0);
    endtask

    task automatic t_off_mode();
        mode = 4'b0100;
        set_pin(1'b1, 16'h0222);
        chk("R7 level high", {15'h0, lvl}, 16'h1);
        chk("R1 A held", ra, 16'h0);
        set_pin(1'b0, 16'h0333);
        chk("R7 level low", {15'h0, lvl}, 16'h0);
        chk("R1 flag held", {15'h0, flag}, 16'h0);
    endtask

    task automatic t_latency();
        // R3: load lands on the third posedge after the pin changes
        mode = 4'b0010;
        @(negedge clk); tbase = 16'h0500; pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 not yet", ra, 16'h0);
        @(negedge clk);
        chk("R3 loaded", ra, 16'h0500);
        chk("R5 first no flag", {15'h0, flag}, 16'h0);
        chk("R4 B still reset", rb, 16'h0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_rising_pipe();
        set_pin(1'b0, 16'h0777);
        chk("R2 falling ignored", ra, 16'h0500);
        set_pin(1'b1, 16'h1000);
        chk("R6 second sets flag", {15'h0, flag}, 16'h1);
        chk("R4 B older", rb, 16'h0500);
        chk("R11 period", ra - rb, 16'h0B00);
        set_pin(1'b0, 16'h1050);
        set_pin(1'b1, 16'h1100);
        chk("R4 B shifts", rb, 16'h1000);
        chk("R3 A newest", ra, 16'h1100);
    endtask

    task automatic t_sticky();
        repeat (5) @(negedge clk);
        chk("R8 flag sticky", {15'h0, flag}, 16'h1);
        do_clear();
        chk("R8 clear", {15'h0, flag}, 16'h0);
    endtask

    task automatic t_collision();
        set_pin(1'b0, 16'h1200);
        set_pin(1'b1, 16'h1300);
        chk("R6 flag again", {15'h0, flag}, 16'h1);
        set_pin(1'b0, 16'h1350);
        @(negedge clk); tbase = 16'h1400; pin = 1'b1;
        @(negedge clk);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R9 set beats clear", {15'h0, flag}, 16'h1);
        chk("R9 capture done", ra, 16'h1400);
        do_clear();
    endtask

    task automatic t_polarity();
        fall_sel = 1'b1;
        set_pin(1'b0, 16'h2000);
        chk("R2 falling captures", ra, 16'h2000);
        chk("R10 pol change first", {15'h0, flag}, 16'h0);
        set_pin(1'b1, 16'h2100);
        chk("R2 rising ignored", ra, 16'h2000);
        set_pin(1'b0, 16'h2300);
        chk("R6 falling pair flag", {15'h0, flag}, 16'h1);
        chk("R11 falling period", ra - rb, 16'h0300);
        do_clear();
    endtask

    task automatic t_reenter_wrap();
        mode = 4'b0000;
        repeat (2) @(negedge clk);
        mode = 4'b0010;
        set_pin(1'b1, 16'hFF00);
        set_pin(1'b0, 16'hFFF0);
        chk("R10 re-entry first", {15'h0, flag}, 16'h0);
        set_pin(1'b1, 16'h0040);
        set_pin(1'b0, 16'h0080);
        chk("R6 after re-entry", {15'h0, flag}, 16'h1);
        chk("R11 wrap period", ra - rb, 16'h0090);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off_mode();
        t_latency();
        t_rising_pipe();
        t_sticky();
        t_collision();
        t_polarity();
        t_reenter_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule